// File: doc/BRIEF.md
# In-Order Load Return Unit

This unit sits between the load pipeline and the integer register file. It tracks every load sent to the data cache and hands each load's destination tag back to the register file strictly in the order the loads were issued. Each load presents its cache outcome (hit or miss), an access size, a sign-extension flag and the low three address bits in the cycle it issues. The unit works out when each result may leave, keeps younger hits waiting behind an older miss until the miss is filled, and slows the return of loads following a signed narrow load.

A load whose low address bits do not match its access size is rejected. It raises a trap one cycle later and never writes back. Outstanding loads sit in a bounded queue. When that queue is full the unit asks the issue logic to hold, and any load offered while the hold is raised is dropped. Cache fills arrive as a single pulse that completes the oldest outstanding miss.

Top module: `lret_unit`

## Requirements
- R1: An accepted, aligned hit that is not a signed narrow load, issued while the queue is empty and the slow mode is off, writes back its tag exactly two cycles after its issue cycle and not in the cycle between.
- R2: An accepted, aligned hit with `iss_signed`=1 and `iss_size` below 3 writes back three cycles after issue when the queue is empty. Size encoding: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit.
- R3: After a signed narrow load is accepted, each load accepted in the directly following cycles also takes three cycles, whatever its own size or sign. This continues while every cycle brings an accepted load.
- R4: The slow mode ends after the first cycle with no accepted load. The next load takes two cycles again, unless it is itself signed narrow.
- R5: Writebacks leave in issue order. A missing load holds back every younger load, including hits that would otherwise be ready.
- R6: A `fill_valid` pulse completes the oldest outstanding miss, which writes back in the next cycle if it is at the head of the queue. A pulse with no miss outstanding has no effect, and a later miss still waits for its own pulse.
- R7: A load is misaligned when a 16-bit access has address bit 0 set, a 32-bit access has either of bits 1:0 set, or a 64-bit access has any of bits 2:0 set; 8-bit accesses are never misaligned. A misaligned load raises `trap_valid` with its tag in the next cycle and never writes back.
- R8: Every accepted aligned load produces exactly one writeback, and at most one writeback leaves per cycle.
- R9: `iss_stall` is high while DEPTH loads are outstanding. A load offered while it is high is ignored: no writeback and no trap.
- R10: During and directly after reset, `wb_valid`, `trap_valid` and `iss_stall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | A load issues this cycle |
| iss_tag | input | TAGW | Destination register tag of the load |
| iss_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 doubleword |
| iss_signed | input | 1 | Load sign-extends its result |
| iss_addr | input | 3 | Low three address bits |
| iss_hit | input | 1 | Data cache hit for this load |
| iss_stall | output | 1 | Queue full; issue must hold |
| fill_valid | input | 1 | Completes the oldest outstanding miss |
| wb_valid | output | 1 | A result is written back this cycle |
| wb_tag | output | TAGW | Tag of the result being written back |
| trap_valid | output | 1 | Misaligned load trap |
| trap_tag | output | TAGW | Tag of the trapping load |

## Verification
On every cycle the assertions check the fixed latencies from an empty queue: two cycles for an ordinary hit and three for a signed narrow one. They also check the trap-or-no-trap outcome of every accepted load, that a load offered under hold never traps, that a fresh miss never writes back in the following cycle, and the reset outputs. The slow mode carried through back-to-back loads, hits held behind a miss, spurious fills, filling a full queue, and the exact count of writebacks depend on sequences of loads. Only the bench's scenarios show those, alongside a sweep of every size, sign and address offset.

// File: rtl/lret_pkg.sv
package lret_pkg;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } acc_size_e;

    localparam logic [1:0] WAIT_FAST = 2'd1;
    localparam logic [1:0] WAIT_SLOW = 2'd2;

    typedef struct packed {
        logic       miss;
        logic [1:0] wait_cnt;
    } slot_t;

    function automatic logic is_misaligned(acc_size_e sz, logic [2:0] a);
        case (sz)
            SZ_B:    return 1'b0;
            SZ_H:    return a[0];
            SZ_W:    return |a[1:0];
            default: return |a;
        endcase
    endfunction

    function automatic logic is_signed_narrow(acc_size_e sz, logic sgn);
        return sgn && (sz != SZ_D);
    endfunction

endpackage

// File: rtl/lret_issue_dec.sv
module lret_issue_dec
    import lret_pkg::*;
#(
    parameter int TAGW = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            iss_valid,
    input  logic            hold,
    input  logic [TAGW-1:0] iss_tag,
    input  acc_size_e       iss_size,
    input  logic            iss_signed,
    input  logic [2:0]      iss_addr,
    output logic            enq,
    output logic [1:0]      enq_wait,
    output logic            trap_valid,
    output logic [TAGW-1:0] trap_tag,
    output logic            dly_mode
);
    logic accepted;
    logic bad_align;
    logic narrow_s;

    assign accepted  = iss_valid && !hold;
    assign bad_align = is_misaligned(iss_size, iss_addr);
    assign narrow_s  = is_signed_narrow(iss_size, iss_signed);
    assign enq       = accepted && !bad_align;
    assign enq_wait  = (narrow_s || dly_mode) ? WAIT_SLOW : WAIT_FAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_mode   <= 1'b0;
            trap_valid <= 1'b0;
            trap_tag   <= '0;
        end else begin
            dly_mode   <= enq ? (dly_mode || narrow_s) : 1'b0;
            trap_valid <= accepted && bad_align;
            trap_tag   <= iss_tag;
        end
    end
endmodule

// File: rtl/lret_order_q.sv
module lret_order_q
    import lret_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAGW  = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enq,
    input  logic [TAGW-1:0] enq_tag,
    input  logic [1:0]      enq_wait,
    input  logic            enq_miss,
    input  logic            fill_valid,
    output logic            wb_valid,
    output logic [TAGW-1:0] wb_tag,
    output logic            full,
    output logic            empty
);
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    slot_t           slots [DEPTH];
    logic [TAGW-1:0] tags  [DEPTH];
    logic [PTRW-1:0] rd_ptr, wr_ptr;
    logic [CNTW-1:0] count;
    logic            fill_hit;
    logic [PTRW-1:0] fill_idx;
    logic [PTRW-1:0] scan;

    function automatic logic [PTRW-1:0] step(logic [PTRW-1:0] p);
        return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty    = (count == '0);
    assign full     = (count == CNTW'(DEPTH));
    assign wb_valid = !empty && !slots[rd_ptr].miss && (slots[rd_ptr].wait_cnt == 2'd0);
    assign wb_tag   = tags[rd_ptr];

    always_comb begin
        fill_hit = 1'b0;
        fill_idx = '0;
        scan     = '0;
        for (int i = 0; i < DEPTH; i++) begin
            scan = PTRW'((int'(rd_ptr) + i) % DEPTH);
            if (!fill_hit && fill_valid && (i < int'(count)) && slots[scan].miss) begin
                fill_hit = 1'b1;
                fill_idx = scan;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
                tags[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (slots[i].wait_cnt != 2'd0)
                    slots[i].wait_cnt <= slots[i].wait_cnt - 2'd1;
            end
            if (fill_hit)
                slots[fill_idx].miss <= 1'b0;
            if (enq) begin
                slots[wr_ptr] <= '{miss: enq_miss, wait_cnt: enq_wait};
                tags[wr_ptr]  <= enq_tag;
                wr_ptr        <= step(wr_ptr);
            end
            if (wb_valid)
                rd_ptr <= step(rd_ptr);
            case ({enq, wb_valid})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/lret_unit.sv
module lret_unit
    import lret_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAGW  = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            iss_valid,
    input  logic [TAGW-1:0] iss_tag,
    input  logic [1:0]      iss_size,
    input  logic            iss_signed,
    input  logic [2:0]      iss_addr,
    input  logic            iss_hit,
    output logic            iss_stall,
    input  logic            fill_valid,
    output logic            wb_valid,
    output logic [TAGW-1:0] wb_tag,
    output logic            trap_valid,
    output logic [TAGW-1:0] trap_tag
);
    logic       enq;
    logic [1:0] enq_wait;
    logic       dly_mode;
    logic       q_full;
    logic       q_empty;

    assign iss_stall = q_full;

    lret_issue_dec #(.TAGW(TAGW)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .iss_valid  (iss_valid),
        .hold       (q_full),
        .iss_tag    (iss_tag),
        .iss_size   (acc_size_e'(iss_size)),
        .iss_signed (iss_signed),
        .iss_addr   (iss_addr),
        .enq        (enq),
        .enq_wait   (enq_wait),
        .trap_valid (trap_valid),
        .trap_tag   (trap_tag),
        .dly_mode   (dly_mode)
    );

    lret_order_q #(.DEPTH(DEPTH), .TAGW(TAGW)) u_q (
        .clk        (clk),
        .rst        (rst),
        .enq        (enq),
        .enq_tag    (iss_tag),
        .enq_wait   (enq_wait),
        .enq_miss   (!iss_hit),
        .fill_valid (fill_valid),
        .wb_valid   (wb_valid),
        .wb_tag     (wb_tag),
        .full       (q_full),
        .empty      (q_empty)
    );
endmodule

// File: rtl/lret_unit_chk.sv
module lret_unit_chk
    import lret_pkg::*;
#(
    parameter int TAGW = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            iss_valid,
    input logic [TAGW-1:0] iss_tag,
    input logic [1:0]      iss_size,
    input logic            iss_signed,
    input logic [2:0]      iss_addr,
    input logic            iss_hit,
    input logic            iss_stall,
    input logic            wb_valid,
    input logic [TAGW-1:0] wb_tag,
    input logic            trap_valid,
    input logic [TAGW-1:0] trap_tag,
    input logic            dly_mode,
    input logic            q_empty
);
    logic taken;
    logic odd_addr;
    assign taken    = iss_valid && !iss_stall;
    assign odd_addr = is_misaligned(acc_size_e'(iss_size), iss_addr);

    assert_fast_hit_R1: assert property (@(posedge clk) disable iff (rst)
        (taken && !odd_addr && iss_hit && iss_size == 2'd3 && !dly_mode && q_empty)
        |=> !wb_valid ##1 (wb_valid && wb_tag == $past(iss_tag, 2)));

    assert_slow_hit_R2: assert property (@(posedge clk) disable iff (rst)
        (taken && !odd_addr && iss_hit && iss_signed && iss_size != 2'd3 && q_empty)
        |=> !wb_valid ##1 !wb_valid ##1 (wb_valid && wb_tag == $past(iss_tag, 3)));

    assert_miss_waits_R6: assert property (@(posedge clk) disable iff (rst)
        (taken && !odd_addr && !iss_hit && q_empty) |=> !wb_valid);

    assert_trap_raised_R7: assert property (@(posedge clk) disable iff (rst)
        (taken && odd_addr) |=> (trap_valid && trap_tag == $past(iss_tag)));

    assert_no_trap_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        (taken && !odd_addr) |=> !trap_valid);

    assert_stalled_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_stall) |=> !trap_valid);

    assert_quiet_reset_R10: assert property (@(posedge clk)
        rst |=> (!wb_valid && !trap_valid && !iss_stall));
endmodule

bind lret_unit lret_unit_chk #(.TAGW(TAGW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .iss_valid  (iss_valid),
    .iss_tag    (iss_tag),
    .iss_size   (iss_size),
    .iss_signed (iss_signed),
    .iss_addr   (iss_addr),
    .iss_hit    (iss_hit),
    .iss_stall  (iss_stall),
    .wb_valid   (wb_valid),
    .wb_tag     (wb_tag),
    .trap_valid (trap_valid),
    .trap_tag   (trap_tag),
    .dly_mode   (dly_mode),
    .q_empty    (q_empty)
);

// File: tb/lret_unit_test.sv
`timescale 1ns/1ps
module lret_unit_test;
    localparam int DEPTH = 8;
    localparam int TAGW  = 5;
    localparam int LOGN  = 4096;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            iss_valid = 1'b0;
    logic [TAGW-1:0] iss_tag = '0;
    logic [1:0]      iss_size = '0;
    logic            iss_signed = 1'b0;
    logic [2:0]      iss_addr = '0;
    logic            iss_hit = 1'b0;
    logic            iss_stall;
    logic            fill_valid = 1'b0;
    logic            wb_valid;
    logic [TAGW-1:0] wb_tag;
    logic            trap_valid;
    logic [TAGW-1:0] trap_tag;

    always #4 clk = ~clk;

    lret_unit #(.DEPTH(DEPTH), .TAGW(TAGW)) uut (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_tag(iss_tag),
        .iss_size(iss_size), .iss_signed(iss_signed), .iss_addr(iss_addr),
        .iss_hit(iss_hit), .iss_stall(iss_stall), .fill_valid(fill_valid),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .trap_valid(trap_valid),
        .trap_tag(trap_tag)
    );

    int cyc = 0;
    int nchk = 0;
    int nfail = 0;
    int nwb = 0;
    int exp_wb = 0;
    bit last_stall;
    bit             wbv [LOGN];
    logic [TAGW-1:0] wbt [LOGN];
    bit             trv [LOGN];
    logic [TAGW-1:0] trt [LOGN];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cyc < LOGN) begin
            wbv[cyc] = wb_valid;
            wbt[cyc] = wb_tag;
            trv[cyc] = trap_valid;
            trt[cyc] = trap_tag;
        end
        if (!rst && wb_valid) nwb++;
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(bit v, int t, int sz, bit s, int a, bit h, bit f, output int at);
        @(negedge clk);
        iss_valid  = v;
        iss_tag    = TAGW'(t);
        iss_size   = 2'(sz);
        iss_signed = s;
        iss_addr   = 3'(a);
        iss_hit    = h;
        fill_valid = f;
        last_stall = iss_stall;
        at = cyc;
    endtask

    task automatic ld(int t, int sz, bit s, int a, bit h, output int at);
        drive(1'b1, t, sz, s, a, h, 1'b0, at);
    endtask

    task automatic idle(int n);
        int at;
        for (int i = 0; i < n; i++) drive(1'b0, 0, 0, 1'b0, 0, 1'b1, 1'b0, at);
    endtask

    task automatic fill(output int at);
        drive(1'b0, 0, 0, 1'b0, 0, 1'b1, 1'b1, at);
    endtask

    task automatic expect_wb(int c, int tag, string req);
        chk(wbv[c] && (int'(wbt[c]) == tag), req, "writeback tag", wbv[c] ? int'(wbt[c]) : -1, tag);
    endtask

    task automatic expect_none(int c0, int c1, string req);
        int n = 0;
        for (int c = c0; c <= c1; c++) if (wbv[c]) n++;
        chk(n == 0, req, "unexpected writebacks", n, 0);
    endtask

    initial begin
        int at, a0, tg, lat;
        int tags [8];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: quiet outputs after reset
        chk(!wb_valid && !trap_valid && !iss_stall, "R10", "outputs after reset",
            int'(wb_valid) + int'(trap_valid) + int'(iss_stall), 0);

        // R1 R2 R7: sweep every size, sign and address offset
        for (int sz = 0; sz < 4; sz++) begin
            for (int s = 0; s < 2; s++) begin
                for (int a = 0; a < 8; a++) begin
                    tg = (sz * 16 + s * 8 + a) % 32;
                    ld(tg, sz, s[0], a, 1'b1, at);
                    idle(4);
                    if ((a % (1 << sz)) != 0) begin
                        chk(trv[at+1] && int'(trt[at+1]) == tg, "R7", "trap tag",
                            trv[at+1] ? int'(trt[at+1]) : -1, tg);
                        expect_none(at + 1, at + 3, "R7");
                    end else begin
                        exp_wb++;
                        lat = (s == 1 && sz < 3) ? 3 : 2;
                        chk(!trv[at+1], "R7", "trap on aligned load", int'(trv[at+1]), 0);
                        expect_none(at + 1, at + lat - 1, lat == 3 ? "R2" : "R1");
                        expect_wb(at + lat, tg, lat == 3 ? "R2" : "R1");
                    end
                end
            end
        end

        // R3 R4: slow mode through back-to-back loads, ends after a gap
        ld(1, 0, 1'b1, 0, 1'b1, a0);
        ld(2, 3, 1'b0, 0, 1'b1, at);
        ld(3, 3, 1'b0, 0, 1'b1, at);
        ld(4, 0, 1'b0, 5, 1'b1, at);
        idle(1);
        ld(5, 3, 1'b0, 0, 1'b1, at);
        idle(6);
        exp_wb += 5;
        expect_wb(a0 + 3, 1, "R3");
        expect_wb(a0 + 4, 2, "R3");
        expect_wb(a0 + 5, 3, "R3");
        expect_wb(a0 + 6, 4, "R3");
        expect_wb(a0 + 7, 5, "R4");
        expect_none(a0 + 8, a0 + 9, "R4");

        // R5 R6: hits held behind an older miss
        ld(10, 3, 1'b0, 0, 1'b0, a0);
        ld(11, 3, 1'b0, 0, 1'b1, at);
        ld(12, 2, 1'b1, 4, 1'b1, at);
        idle(7);
        fill(at);
        idle(6);
        exp_wb += 3;
        expect_none(a0 + 1, a0 + 10, "R5");
        expect_wb(a0 + 11, 10, "R6");
        expect_wb(a0 + 12, 11, "R5");
        expect_wb(a0 + 13, 12, "R5");

        // R6: a fill with nothing outstanding is ignored
        fill(at);
        ld(13, 1, 1'b0, 2, 1'b0, a0);
        idle(8);
        expect_none(a0 + 1, a0 + 8, "R6");
        fill(at);
        idle(4);
        exp_wb++;
        expect_wb(at + 1, 13, "R6");

        // R9: fill the queue with misses, offer a load under hold, drain
        for (int i = 0; i < DEPTH; i++) begin
            ld(16 + i, 3, 1'b0, 0, 1'b0, at);
            chk(!last_stall, "R9", "hold before full", int'(last_stall), 0);
        end
        ld(31, 1, 1'b0, 1, 1'b1, a0);
        chk(last_stall, "R9", "hold when full", int'(last_stall), 1);
        idle(3);
        chk(!trv[a0+1], "R9", "trap from held load", int'(trv[a0+1]), 0);
        expect_none(a0, a0 + 2, "R9");
        for (int i = 0; i < DEPTH; i++) begin
            fill(at);
            tags[i] = at;
        end
        idle(4);
        exp_wb += DEPTH;
        for (int i = 0; i < DEPTH; i++) expect_wb(tags[i] + 1, 16 + i, "R5");
        chk(!iss_stall, "R9", "hold after drain", int'(iss_stall), 0);

        // R8: exactly one writeback per accepted aligned load
        chk(nwb == exp_wb, "R8", "writeback count", nwb, exp_wb);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule